// File: doc/BRIEF.md
# Banked Cluster Memory Request Arbiter

This block sits in front of a cluster-local memory built from sixteen independent 64-bit banks, split into a left group and a right group of eight. Every requester presents a byte address, a write enable and write data. The address is turned into a bank number and a word index. A static mode input picks one of two mappings. The interleaved mapping spreads consecutive 64-byte lines over all banks. The blocked mapping gives each bank one contiguous slice of the address space. Bank bit 0 is the side in the interleaved mapping, and the bank MSB is the side in the blocked mapping.

There are twelve masters: four system masters and eight core-pair paths. Each core-pair path carries four sources, which are the instruction and data caches of two cores. Arbitration runs in two round-robin levels, both resolved in the same cycle as the request. The first level picks one source per core pair. The second level picks one master per bank. A source holds its request until it sees its grant. A read returns data a fixed number of cycles after the grant. The return arrives on the granted master's response lane, and for core-pair lanes it carries the index of the source within the pair. The default bank depth is kept small. A full-size bank is 14 word-address bits, set through `WORD_AW`.

Top module: `smem_arbiter`

## Requirements
- R1: With `interleave_i`=1, the bank is byte-address bits [9:6] and the word index is {address bits above 9, bits [5:3]}. Bank bit 0 (address bit 6) selects the side, so consecutive 64-byte lines alternate sides.
- R2: With `interleave_i`=0, the bank is the top four address bits and the word index is address bits [WORD_AW+2:3]. The address MSB is the side: the lower half of the space maps to banks 0-7, and the upper half maps to banks 8-15.
- R3: In any cycle each bank grants at most one master, and each master is granted for at most one bank.
- R4: Each bank arbitrates round-robin over master indices 0 NoC receive, 1 NoC transmit DMA, 2 debug unit, 3 resource manager, and 4+p core pair p. Its pointer moves to just past the winner only when it grants, and starts at master 0 after reset.
- R5: Each core pair picks round-robin among its sources k=0 core0 instruction, 1 core0 data, 2 core1 instruction and 3 core1 data, found at `req_i` index 4+4p+k. Its pointer moves past the picked source only when the pair wins its bank. At most one source per pair is granted per cycle.
- R6: A read granted to a system master in cycle T gives `rsp_valid_o` for that master in cycle T+3, with the addressed word and `rsp_src_o`=0.
- R7: A read granted to core-pair source k in cycle T gives `rsp_valid_o[4+p]` in cycle T+4, with the addressed word and `rsp_src_o` slice = k.
- R8: A write gives no response. A later read of the same bank and word returns the written data, and operations on one bank take effect in grant order.
- R9: After reset no response is valid and, without requests, no grant is given.
- R10: `gnt_o` is combinational: a request that wins is granted in its own cycle, no grant is given without a request, and a losing source keeps requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interleave_i | input | 1 | 1 selects the interleaved mapping, 0 the blocked mapping; changed only while idle |
| req_i | input | 36 | Request per source: 0-3 system masters, 4+4p+k core-pair sources |
| we_i | input | 36 | Write enable per source |
| addr_i | input | 36*13 | Byte address per source, source s at bits [s*13 +: 13] |
| wdata_i | input | 36*64 | Write data per source |
| gnt_o | output | 36 | Grant per source, same cycle as the winning request |
| rsp_valid_o | output | 12 | Read data valid per master lane |
| rsp_src_o | output | 12*2 | Source index within the pair for each lane |
| rsp_data_o | output | 12*64 | Read data per master lane |

## Verification
The hardest case to reach is the one where both arbitration levels interact. A core pair must hold several sources at once while its bank is also wanted by other masters, so that the pair pointer must stay put on lost rounds and advance only on wins. The stimulus reaches it with hot phases, where every source requests continuously into only two banks. The same pattern is also run against both mappings. A memory filled under the interleaved mapping is then read under the blocked mapping. This means data comparisons only pass if both decodes land on the same physical bank and word.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int DATA_W    = 64;
  localparam int NUM_SYS   = 4;
  localparam int PAIR_SRCS = 4;
  localparam int SUB_W     = 2;
endpackage

// File: rtl/smem_rr_arb.sv
module smem_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [IW-1:0] ptr_q;
  int c;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    c = 0;
    for (int i = 0; i < N; i++) begin
      c = (int'(ptr_q) + i) % N;
      if (!any_o && req_i[c]) begin
        any_o    = 1'b1;
        gnt_o[c] = 1'b1;
        idx_o    = IW'(c);
      end
    end
  end

  // pointer moves only when the winner is actually served
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && any_o) ptr_q <= (idx_o == IW'(N-1)) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/smem_addr_map.sv
module smem_addr_map #(
  parameter int AW        = 13,
  parameter int WORD_AW   = 6,
  parameter int BANK_BITS = 4,
  parameter int LINE_OFF  = 6,
  parameter int WORD_OFF  = 3,
  localparam int LOW_W    = LINE_OFF - WORD_OFF,
  localparam int HIGH_W   = WORD_AW - LOW_W
) (
  input  logic                 interleave_i,
  input  logic [AW-1:0]        addr_i,
  output logic [BANK_BITS-1:0] bank_o,
  output logic [WORD_AW-1:0]   word_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[WORD_OFF-1:0];

  always_comb begin
    if (interleave_i) begin
      bank_o = addr_i[LINE_OFF +: BANK_BITS];
      word_o = {addr_i[AW-1 -: HIGH_W], addr_i[WORD_OFF +: LOW_W]};
    end else begin
      bank_o = addr_i[AW-1 -: BANK_BITS];
      word_o = addr_i[WORD_OFF +: WORD_AW];
    end
  end
endmodule

// File: rtl/smem_bank.sv
module smem_bank #(
  parameter int WORD_AW = 6,
  parameter int MW      = 4,
  parameter int SW      = 2,
  parameter int DW      = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [WORD_AW-1:0] word_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [MW-1:0]      mst_i,
  input  logic [SW-1:0]      sub_i,
  output logic               rvalid_o,
  output logic [MW-1:0]      rmst_o,
  output logic [SW-1:0]      rsub_o,
  output logic [DW-1:0]      rdata_o
);
  localparam int DEPTH = 2 ** WORD_AW;

  logic               s1_v, s1_we;
  logic [WORD_AW-1:0] s1_word;
  logic [DW-1:0]      s1_wdata;
  logic [MW-1:0]      s1_mst;
  logic [SW-1:0]      s1_sub;
  logic [DW-1:0]      mem_q [DEPTH];
  logic [DW-1:0]      rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_we <= 1'b0; s1_word <= '0; s1_wdata <= '0;
      s1_mst <= '0; s1_sub <= '0;
      rvalid_o <= 1'b0; rmst_o <= '0; rsub_o <= '0;
    end else begin
      s1_v <= req_i; s1_we <= we_i; s1_word <= word_i; s1_wdata <= wdata_i;
      s1_mst <= mst_i; s1_sub <= sub_i;
      rvalid_o <= s1_v && !s1_we;
      rmst_o <= s1_mst; rsub_o <= s1_sub;
    end
  end

  always_ff @(posedge clk_i) begin
    if (s1_v && s1_we) mem_q[s1_word] <= s1_wdata;
    if (s1_v && !s1_we) rdata_q <= mem_q[s1_word];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/smem_arbiter.sv
module smem_arbiter #(
  parameter int NUM_BANKS  = 16,
  parameter int NUM_PAIRS  = 8,
  parameter int WORD_AW    = 6,
  parameter int LINE_BYTES = 64,
  localparam int DW   = smem_pkg::DATA_W,
  localparam int NSYS = smem_pkg::NUM_SYS,
  localparam int PS   = smem_pkg::PAIR_SRCS,
  localparam int SW   = smem_pkg::SUB_W,
  localparam int BB   = $clog2(NUM_BANKS),
  localparam int WOFF = $clog2(DW / 8),
  localparam int LOFF = $clog2(LINE_BYTES),
  localparam int AW   = WOFF + WORD_AW + BB,
  localparam int NMST = NSYS + NUM_PAIRS,
  localparam int NSRC = NSYS + PS * NUM_PAIRS,
  localparam int MW   = $clog2(NMST)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 interleave_i,
  input  logic [NSRC-1:0]      req_i,
  input  logic [NSRC-1:0]      we_i,
  input  logic [NSRC*AW-1:0]   addr_i,
  input  logic [NSRC*DW-1:0]   wdata_i,
  output logic [NSRC-1:0]      gnt_o,
  output logic [NMST-1:0]      rsp_valid_o,
  output logic [NMST*SW-1:0]   rsp_src_o,
  output logic [NMST*DW-1:0]   rsp_data_o
);
  logic [NMST-1:0]    m_req, m_gnt;
  logic               m_we    [NMST];
  logic [AW-1:0]      m_addr  [NMST];
  logic [DW-1:0]      m_wdata [NMST];
  logic [SW-1:0]      m_sub   [NMST];
  logic [BB-1:0]      m_bank  [NMST];
  logic [WORD_AW-1:0] m_word  [NMST];

  logic [PS-1:0]      pick [NUM_PAIRS];
  logic [SW-1:0]      pidx [NUM_PAIRS];

  logic [NMST-1:0]    bank_gnt [NUM_BANKS];
  logic [MW-1:0]      bank_idx [NUM_BANKS];
  logic               bank_any [NUM_BANKS];
  logic               rv  [NUM_BANKS];
  logic [MW-1:0]      rmst[NUM_BANKS];
  logic [SW-1:0]      rsub[NUM_BANKS];
  logic [DW-1:0]      rdat[NUM_BANKS];

  // system masters feed the bank level directly
  for (genvar s = 0; s < NSYS; s++) begin : g_sys
    assign m_req[s]   = req_i[s];
    assign m_we[s]    = we_i[s];
    assign m_addr[s]  = addr_i[s*AW +: AW];
    assign m_wdata[s] = wdata_i[s*DW +: DW];
    assign m_sub[s]   = '0;
    assign gnt_o[s]   = m_gnt[s];
  end

  // first level: one source per core pair
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int BASE = NSYS + PS * p;
    smem_rr_arb #(.N(PS)) u_pair_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req_i[BASE +: PS]),
      .adv_i (m_gnt[NSYS+p]),
      .gnt_o (pick[p]),
      .idx_o (pidx[p]),
      .any_o (m_req[NSYS+p])
    );
    assign m_we[NSYS+p]    = we_i[BASE + int'(pidx[p])];
    assign m_addr[NSYS+p]  = addr_i[(BASE + int'(pidx[p]))*AW +: AW];
    assign m_wdata[NSYS+p] = wdata_i[(BASE + int'(pidx[p]))*DW +: DW];
    assign m_sub[NSYS+p]   = pidx[p];
    assign gnt_o[BASE +: PS] = pick[p] & {PS{m_gnt[NSYS+p]}};
  end

  for (genvar m = 0; m < NMST; m++) begin : g_map
    smem_addr_map #(
      .AW(AW), .WORD_AW(WORD_AW), .BANK_BITS(BB), .LINE_OFF(LOFF), .WORD_OFF(WOFF)
    ) u_map (
      .interleave_i(interleave_i),
      .addr_i      (m_addr[m]),
      .bank_o      (m_bank[m]),
      .word_o      (m_word[m])
    );
  end

  // second level: one master per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NMST-1:0] breq;
    always_comb begin
      for (int m = 0; m < NMST; m++) breq[m] = m_req[m] && (m_bank[m] == BB'(b));
    end
    smem_rr_arb #(.N(NMST)) u_bank_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (breq),
      .adv_i (1'b1),
      .gnt_o (bank_gnt[b]),
      .idx_o (bank_idx[b]),
      .any_o (bank_any[b])
    );
    smem_bank #(.WORD_AW(WORD_AW), .MW(MW), .SW(SW), .DW(DW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (bank_any[b]),
      .we_i    (m_we[bank_idx[b]]),
      .word_i  (m_word[bank_idx[b]]),
      .wdata_i (m_wdata[bank_idx[b]]),
      .mst_i   (bank_idx[b]),
      .sub_i   (m_sub[bank_idx[b]]),
      .rvalid_o(rv[b]),
      .rmst_o  (rmst[b]),
      .rsub_o  (rsub[b]),
      .rdata_o (rdat[b])
    );
  end

  always_comb begin
    m_gnt = '0;
    for (int b = 0; b < NUM_BANKS; b++) m_gnt |= bank_gnt[b];
  end

  // return path: each master has at most one read in flight per stage
  logic          hv [NMST];
  logic [SW-1:0] hs [NMST];
  logic [DW-1:0] hd [NMST];

  always_comb begin
    for (int m = 0; m < NMST; m++) begin
      hv[m] = 1'b0; hs[m] = '0; hd[m] = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (rv[b] && rmst[b] == MW'(m)) begin
          hv[m] = 1'b1; hs[m] = rsub[b]; hd[m] = rdat[b];
        end
      end
    end
  end

  for (genvar m = 0; m < NMST; m++) begin : g_rsp
    logic          o_v;
    logic [SW-1:0] o_s;
    logic [DW-1:0] o_d;
    if (m < NSYS) begin : g_short
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          o_v <= 1'b0; o_s <= '0; o_d <= '0;
        end else begin
          o_v <= hv[m]; o_s <= hs[m]; o_d <= hd[m];
        end
      end
    end else begin : g_long
      logic          x_v;
      logic [SW-1:0] x_s;
      logic [DW-1:0] x_d;
      // extra register on the shared core-pair return path
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          x_v <= 1'b0; x_s <= '0; x_d <= '0;
          o_v <= 1'b0; o_s <= '0; o_d <= '0;
        end else begin
          x_v <= hv[m]; x_s <= hs[m]; x_d <= hd[m];
          o_v <= x_v;   o_s <= x_s;   o_d <= x_d;
        end
      end
    end
    assign rsp_valid_o[m]         = o_v;
    assign rsp_src_o[m*SW +: SW]  = o_s;
    assign rsp_data_o[m*DW +: DW] = o_d;
  end
endmodule

// File: rtl/smem_arbiter_chk.sv
module smem_arbiter_chk #(
  parameter int NUM_BANKS  = 16,
  parameter int NUM_PAIRS  = 8,
  parameter int WORD_AW    = 6,
  parameter int LINE_BYTES = 64,
  localparam int DW   = smem_pkg::DATA_W,
  localparam int NSYS = smem_pkg::NUM_SYS,
  localparam int PS   = smem_pkg::PAIR_SRCS,
  localparam int BB   = $clog2(NUM_BANKS),
  localparam int LOFF = $clog2(LINE_BYTES),
  localparam int AW   = $clog2(DW / 8) + WORD_AW + BB,
  localparam int NMST = NSYS + NUM_PAIRS,
  localparam int NSRC = NSYS + PS * NUM_PAIRS
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               interleave_i,
  input logic [NSRC-1:0]    req_i,
  input logic [NSRC-1:0]    we_i,
  input logic [NSRC*AW-1:0] addr_i,
  input logic [NSRC-1:0]    gnt_o,
  input logic [NMST-1:0]    rsp_valid_o
);
  logic unused_chk;
  assign unused_chk = ^addr_i;

  int cnt [NUM_BANKS];
  logic [BB-1:0] bk;

  always_comb begin
    bk = '0;
    for (int b = 0; b < NUM_BANKS; b++) cnt[b] = 0;
    for (int s = 0; s < NSRC; s++) begin
      bk = interleave_i ? addr_i[s*AW + LOFF +: BB] : addr_i[s*AW + AW - BB +: BB];
      if (gnt_o[s]) cnt[int'(bk)] = cnt[int'(bk)] + 1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    p_bank_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt[b] <= 1);
  end

  p_gnt_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  for (genvar s = 0; s < NSYS; s++) begin : g_s
    p_sys_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o[s] |-> $past(gnt_o[s] && !we_i[s], 3));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_p
    p_pair_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_o[NSYS+PS*p +: PS]));
    p_pair_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o[NSYS+p] |-> $past(|(gnt_o[NSYS+PS*p +: PS] & ~we_i[NSYS+PS*p +: PS]), 4));
  end
endmodule

bind smem_arbiter smem_arbiter_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_PAIRS(NUM_PAIRS), .WORD_AW(WORD_AW), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/tb_smem_arbiter.sv
module tb_smem_arbiter;
  localparam int NB = 16, NP = 8, AW = 13, DW = 64;
  localparam int NSYS = 4, NMST = 12, NSRC = 36;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic interleave = 1'b1;
  logic [NSRC-1:0]    req = '0, we = '0;
  logic [NSRC*AW-1:0] addr = '0;
  logic [NSRC*DW-1:0] wdata = '0;
  logic [NSRC-1:0]    gnt;
  logic [NMST-1:0]    rsp_valid;
  logic [NMST*2-1:0]  rsp_src;
  logic [NMST*DW-1:0] rsp_data;

  always #2 clk = ~clk;

  smem_arbiter dut (
    .clk_i(clk), .rst_ni(rst_ni), .interleave_i(interleave),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .gnt_o(gnt), .rsp_valid_o(rsp_valid), .rsp_src_o(rsp_src), .rsp_data_o(rsp_data)
  );

  bit            act [NSRC];
  bit            swe [NSRC];
  logic [AW-1:0] sad [NSRC];
  logic [63:0]   swd [NSRC];
  int bptr [NB];
  int pptr [NP];
  logic [63:0] mem_m [int];
  bit          ev [NMST][8];
  bit          ek [NMST][8];
  logic [63:0] ed [NMST][8];
  int          es [NMST][8];
  int n_chk = 0, n_bad = 0, cyc = 0;

  function automatic int bank_of(logic [AW-1:0] a, bit il);
    return il ? int'((a >> 6) & 15) : int'((a >> 9) & 15);
  endfunction
  function automatic int word_of(logic [AW-1:0] a, bit il);
    return il ? int'((((a >> 10) & 7) << 3) | ((a >> 3) & 7)) : int'((a >> 3) & 63);
  endfunction

  task automatic gen(int pct, bit hot);
    for (int s = 0; s < NSRC; s++) begin
      if (!act[s] && ($urandom % 100) < pct) begin
        logic [AW-1:0] a;
        int hb;
        a = AW'($urandom) & ~AW'(7);
        hb = 5 + int'($urandom % 2);
        if (hot) begin
          if (interleave) a[9:6] = 4'(hb);
          else a[12:9] = 4'(hb);
        end
        act[s] = 1'b1; swe[s] = ($urandom % 3) == 0; sad[s] = a;
        swd[s] = {$urandom, $urandom};
      end
    end
  endtask

  task automatic step();
    int pk [NP];
    bit mreq [NMST];
    int msrc [NMST];
    bit mg [NMST];
    logic [NSRC-1:0] eg;
    int slot;
    @(negedge clk);
    for (int s = 0; s < NSRC; s++) begin
      req[s] = act[s]; we[s] = swe[s];
      addr[s*AW +: AW] = sad[s]; wdata[s*DW +: DW] = swd[s];
    end
    #1;
    for (int p = 0; p < NP; p++) begin
      pk[p] = -1;
      for (int i = 0; i < 4; i++) begin
        int k;
        k = (pptr[p] + i) % 4;
        if (pk[p] < 0 && act[NSYS + 4*p + k]) pk[p] = k;
      end
    end
    for (int m = 0; m < NMST; m++) begin
      mg[m] = 1'b0;
      if (m < NSYS) begin mreq[m] = act[m]; msrc[m] = m; end
      else begin
        mreq[m] = pk[m-NSYS] >= 0;
        msrc[m] = (pk[m-NSYS] >= 0) ? NSYS + 4*(m-NSYS) + pk[m-NSYS] : 0;
      end
    end
    for (int b = 0; b < NB; b++) begin
      bit done;
      done = 1'b0;
      for (int i = 0; i < NMST; i++) begin
        int m;
        m = (bptr[b] + i) % NMST;
        if (!done && mreq[m] && bank_of(sad[msrc[m]], interleave) == b) begin
          done = 1'b1; mg[m] = 1'b1;
        end
      end
    end
    eg = '0;
    for (int m = 0; m < NMST; m++) if (mg[m]) eg[msrc[m]] = 1'b1;
    n_chk++;
    if (gnt !== eg) begin
      n_bad++;
      $display("FAIL R3/R4/R5/R10 grant cyc %0d: actual %h expected %h", cyc, gnt, eg);
    end
    slot = cyc % 8;
    for (int m = 0; m < NMST; m++) begin
      n_chk++;
      if (rsp_valid[m] !== ev[m][slot]) begin
        n_bad++;
        $display("FAIL %s/R8 valid lane %0d cyc %0d: actual %b expected %b",
                 (m < NSYS) ? "R6" : "R7", m, cyc, rsp_valid[m], ev[m][slot]);
      end else if (ev[m][slot]) begin
        if (rsp_src[m*2 +: 2] !== 2'(es[m][slot])) begin
          n_bad++;
          $display("FAIL R7 tag lane %0d: actual %0d expected %0d", m, rsp_src[m*2 +: 2], es[m][slot]);
        end
        if (ek[m][slot] && rsp_data[m*DW +: DW] !== ed[m][slot]) begin
          n_bad++;
          $display("FAIL %s/R8 data lane %0d: actual %h expected %h", interleave ? "R1" : "R2",
                   m, rsp_data[m*DW +: DW], ed[m][slot]);
        end
      end
      ev[m][slot] = 1'b0;
    end
    for (int m = 0; m < NMST; m++) begin
      if (mg[m]) begin
        int s, key, b, sl;
        s = msrc[m];
        b = bank_of(sad[s], interleave);
        key = b * 64 + word_of(sad[s], interleave);
        bptr[b] = (m + 1) % NMST;
        if (m >= NSYS) pptr[m-NSYS] = (pk[m-NSYS] + 1) % 4;
        if (swe[s]) mem_m[key] = swd[s];
        else begin
          sl = (cyc + ((m < NSYS) ? 3 : 4)) % 8;
          ev[m][sl] = 1'b1;
          ek[m][sl] = mem_m.exists(key);
          ed[m][sl] = mem_m.exists(key) ? mem_m[key] : '0;
          es[m][sl] = (m < NSYS) ? 0 : pk[m-NSYS];
        end
        act[s] = 1'b0;
      end
    end
    cyc++;
  endtask

  task automatic drain();
    bit busy;
    busy = 1'b1;
    while (busy) begin
      step();
      busy = 1'b0;
      for (int s = 0; s < NSRC; s++) if (act[s]) busy = 1'b1;
    end
    repeat (6) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) bptr[b] = 0;
    for (int p = 0; p < NP; p++) pptr[p] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    n_chk++;
    if (gnt !== '0 || rsp_valid !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: actual gnt %h valid %h expected 0 0", gnt, rsp_valid);
    end
    // fill every word through the NoC receive master, interleaved mapping (R1)
    for (int w = 0; w < 1024; w++) begin
      act[0] = 1'b1; swe[0] = 1'b1; sad[0] = AW'(w * 8); swd[0] = {$urandom, $urandom};
      step();
    end
    drain();
    repeat (300) begin gen(100, 1'b1); step(); end   // all masters on two banks: R4, R5
    repeat (1500) begin gen(40, 1'b0); step(); end
    drain();
    interleave = 1'b0;                                // blocked mapping (R2)
    repeat (1500) begin gen(40, 1'b0); step(); end
    repeat (300) begin gen(100, 1'b1); step(); end
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule